// File: doc/BRIEF.md
# Two-Lane Pixel Serializer with Sync Lane

This block turns a parallel pixel stream into three serial lanes that share one bit clock: two data lanes and one sync lane. Every word on every lane is seven bit clocks long, and all three lanes start their words on the same clock. The sync lane carries a code that marks each word as a frame start, a valid pixel or an idle slot. The data lanes carry the pixel, split into an upper and a lower 7-bit half and sent most significant bit first.

Pixels arrive through a valid/ready handshake. A start-of-frame flag travels with the first pixel of a frame. A mode input selects full-width 14-bit pixels, used for raw and temperature data, or 10-bit pixels, used for processed data. In 10-bit mode the upper lane is padded with zeros. An enable input switches the serial output on and off. Enable and mode are sampled only at word boundaries, so a word that has already started is never altered.

Top module: `pix_serializer`

## Requirements
- R1: While `rst_n` is low, and for the first seven clocks after it rises, all three lanes and `pix_ready` are 0.
- R2: A word boundary falls once in every seven clocks. `pix_ready` can be high only in the last clock of a word, so it is never high in two consecutive clocks.
- R3: With `narrow_mode`=0, an accepted pixel's bits [13:7] form the lane 2 word and bits [6:0] form the lane 1 word.
- R4: With `narrow_mode`=1, the lane 2 word is four 0 bits followed by pixel bits [9:7], and the lane 1 word is pixel bits [6:0].
- R5: Every lane sends its 7-bit word most significant bit first. The first bit is on the lane in the clock right after the boundary edge.
- R6: When the pending pixel carries `pix_sof` and no frame word has yet been sent for it, the next word is a frame word: sync 1110000, both data lanes 0. `pix_ready` stays low on that boundary. The pixel is accepted at the following boundary.
- R7: A word carrying an accepted pixel has sync code 1100100.
- R8: If no pixel is valid at a boundary while enabled, the word is idle: sync code 1100000 and both data lanes 0.
- R9: If `en` is 0 at a boundary, the whole following word is 0 on all lanes and `pix_ready` is low at that boundary.
- R10: Changes on `en` or `narrow_mode` between boundaries do not alter the word currently being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Output enable, sampled at word boundaries |
| narrow_mode | input | 1 | 1 selects 10-bit pixels, 0 selects 14-bit pixels |
| pix_valid | input | 1 | Pixel offered |
| pix_sof | input | 1 | Offered pixel is the first of a frame |
| pix_data | input | PIX_W | Pixel value |
| pix_ready | output | 1 | Pixel taken at this clock edge |
| lane_d1 | output | 1 | Data lane carrying the low pixel half |
| lane_d2 | output | 1 | Data lane carrying the high pixel half |
| lane_sync | output | 1 | Sync code lane |

## Verification
Frame-word insertion and the enable gate can both act on the same word boundary. A start-of-frame pixel that is waiting for its frame word may meet a boundary at which the output is being turned off. The bench holds such a pixel valid while `en` drops and later rises, at clocks that fall both on and between boundaries. A behavioural queue model, updated once per clock, predicts every lane bit and every `pix_ready` value. It checks three things: no frame code escapes while the output is disabled, the frame word still comes just before its pixel once the output is enabled again, and a change made mid-word leaves the current word untouched.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
   localparam int WORD_LEN  = 7;
   localparam int N_LANES   = 3;
   localparam int LANE_D1   = 0;
   localparam int LANE_D2   = 1;
   localparam int LANE_SYNC = 2;

   localparam logic [WORD_LEN-1:0] SYNC_FRAME = 7'b1110000;
   localparam logic [WORD_LEN-1:0] SYNC_PIXEL = 7'b1100100;
   localparam logic [WORD_LEN-1:0] SYNC_IDLE  = 7'b1100000;

   typedef enum logic [1:0] {
      WK_OFF,
      WK_IDLE,
      WK_FRAME,
      WK_PIXEL
   } word_kind_e;
endpackage

// File: rtl/pxs_word_timer.sv
module pxs_word_timer #(
   parameter int WORD_LEN = 7
) (
   input  logic clk,
   input  logic rst_n,
   output logic word_end
);
   localparam int PH_W = $clog2(WORD_LEN);
   localparam logic [PH_W-1:0] LAST = PH_W'(WORD_LEN - 1);

   generate
      if (WORD_LEN < 2) begin : g_bad_len
         $error("pxs_word_timer: WORD_LEN must be at least 2");
      end
   endgenerate

   logic [PH_W-1:0] phase;

   always_ff @(posedge clk) begin
      if (!rst_n)              phase <= '0;
      else if (phase == LAST)  phase <= '0;
      else                     phase <= phase + 1'b1;
   end

   assign word_end = (phase == LAST);

   AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == LAST) |=> (phase == '0)); // R2
   AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != LAST) |=> (phase == PH_W'($past(phase) + 1'b1))); // R2
endmodule

// File: rtl/pxs_word_builder.sv
module pxs_word_builder
   import pxs_pkg::*;
#(
   parameter int PIX_W    = 14,
   parameter int NARROW_W = 10
) (
   input  word_kind_e                         kind,
   input  logic                               narrow,
   input  logic [PIX_W-1:0]                   pix,
   output logic [N_LANES-1:0][WORD_LEN-1:0]   words
);
   localparam int HI_W  = NARROW_W - WORD_LEN;
   localparam int PAD_W = WORD_LEN - HI_W;

   generate
      if (PIX_W != 2 * WORD_LEN) begin : g_bad_pix
         $error("pxs_word_builder: PIX_W must fill two lane words");
      end
      if (NARROW_W <= WORD_LEN || NARROW_W >= PIX_W) begin : g_bad_narrow
         $error("pxs_word_builder: NARROW_W must lie between one word and PIX_W");
      end
   endgenerate

   logic [WORD_LEN-1:0] hi_wide;
   logic [WORD_LEN-1:0] hi_narrow;
   logic [WORD_LEN-1:0] lo_half;

   assign hi_wide   = pix[PIX_W-1:WORD_LEN];
   assign hi_narrow = {{PAD_W{1'b0}}, pix[NARROW_W-1:WORD_LEN]};
   assign lo_half   = pix[WORD_LEN-1:0];

   always_comb begin
      words = '0;
      unique case (kind)
         WK_IDLE:  words[LANE_SYNC] = SYNC_IDLE;
         WK_FRAME: words[LANE_SYNC] = SYNC_FRAME;
         WK_PIXEL: begin
            words[LANE_SYNC] = SYNC_PIXEL;
            words[LANE_D1]   = lo_half;
            words[LANE_D2]   = narrow ? hi_narrow : hi_wide;
         end
         default:  words = '0;
      endcase
   end
endmodule

// File: rtl/pxs_lane_shifter.sv
module pxs_lane_shifter #(
   parameter int LANES    = 3,
   parameter int WORD_LEN = 7
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             load,
   input  logic [LANES-1:0][WORD_LEN-1:0]   words,
   output logic [LANES-1:0]                 bits
);
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [WORD_LEN-1:0] sr;
         always_ff @(posedge clk) begin
            if (!rst_n)     sr <= '0;
            else if (load)  sr <= words[l];
            else            sr <= {sr[WORD_LEN-2:0], 1'b0};
         end
         assign bits[l] = sr[WORD_LEN-1];
      end
   endgenerate
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
   import pxs_pkg::*;
#(
   parameter int PIX_W    = 14,
   parameter int NARROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             narrow_mode,
   input  logic             pix_valid,
   input  logic             pix_sof,
   input  logic [PIX_W-1:0] pix_data,
   output logic             pix_ready,
   output logic             lane_d1,
   output logic             lane_d2,
   output logic             lane_sync
);
   logic                               word_end;
   logic                               sof_done;
   logic                               need_frame;
   word_kind_e                         kind;
   logic [N_LANES-1:0][WORD_LEN-1:0]   words;
   logic [N_LANES-1:0]                 bits;

   pxs_word_timer #(.WORD_LEN(WORD_LEN)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_end (word_end)
   );

   assign need_frame = pix_valid && pix_sof && !sof_done;

   always_comb begin
      if (!en)             kind = WK_OFF;
      else if (need_frame) kind = WK_FRAME;
      else if (pix_valid)  kind = WK_PIXEL;
      else                 kind = WK_IDLE;
   end

   assign pix_ready = word_end && en && !need_frame;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sof_done <= 1'b0;
      end else if (word_end) begin
         if (kind == WK_FRAME)      sof_done <= 1'b1;
         else if (kind == WK_PIXEL) sof_done <= 1'b0;
      end
   end

   pxs_word_builder #(.PIX_W(PIX_W), .NARROW_W(NARROW_W)) u_builder (
      .kind   (kind),
      .narrow (narrow_mode),
      .pix    (pix_data),
      .words  (words)
   );

   pxs_lane_shifter #(.LANES(N_LANES), .WORD_LEN(WORD_LEN)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (word_end),
      .words (words),
      .bits  (bits)
   );

   assign lane_d1   = bits[LANE_D1];
   assign lane_d2   = bits[LANE_D2];
   assign lane_sync = bits[LANE_SYNC];

   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ready |=> !pix_ready); // R2
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (word_end && !en) |=> (!lane_d1 && !lane_d2 && !lane_sync)); // R9
   AST_SYNC_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (word_end && en) |=> lane_sync); // R5
   AST_FRAME_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_ready && pix_valid && pix_sof) |-> sof_done); // R6
   AST_NARROW_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_ready && pix_valid && narrow_mode) |=> !lane_d2); // R4
   AST_IDLE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (word_end && en && !pix_valid) |=> (!lane_d1 && !lane_d2)); // R8
endmodule

// File: tb/pix_serializer_tb.sv
module pix_serializer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          narrow_mode = 1'b0;
   logic          pix_valid = 1'b0;
   logic          pix_sof = 1'b0;
   logic [PW-1:0] pix_data = '0;
   logic          pix_ready, lane_d1, lane_d2, lane_sync;

   pix_serializer #(.PIX_W(PW), .NARROW_W(10)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .narrow_mode(narrow_mode),
      .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_data(pix_data),
      .pix_ready(pix_ready), .lane_d1(lane_d1), .lane_d2(lane_d2),
      .lane_sync(lane_sync)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Behavioural model: bit queues per lane, filled seven bits at a time.
   bit q1[$];
   bit q2[$];
   bit qs[$];
   int kq[$];   // 0 off, 1 idle, 2 frame, 3 wide pixel, 4 narrow pixel
   int ph_m = 0;
   bit sofd_m = 1'b0;
   bit en_b = 1'b0;
   bit mode_b = 1'b0;

   always @(negedge clk) begin
      bit e1, e2, es, starting, exp_rdy;
      int k;
      string tag;
      logic [6:0] w1, w2, ws;
      if (!rst_n) begin
         chk(lane_d1 == 1'b0 && lane_d2 == 1'b0 && lane_sync == 1'b0, "R1 reset lanes",
             {lane_sync, lane_d2, lane_d1}, 0);
         chk(pix_ready == 1'b0, "R1 reset ready", pix_ready, 0);
      end else begin
         e1 = (q1.size() > 0) ? q1[0] : 1'b0;
         e2 = (q2.size() > 0) ? q2[0] : 1'b0;
         es = (qs.size() > 0) ? qs[0] : 1'b0;
         k  = (kq.size() > 0) ? kq[0] : -1;
         case (k)
            -1: tag = "R1";
            0:  tag = "R9";
            1:  tag = "R8";
            2:  tag = "R6";
            3:  tag = "R3 R5 R7";
            default: tag = "R4 R5 R7";
         endcase
         if (ph_m != 6 && k >= 0 && (en != en_b || narrow_mode != mode_b))
            tag = {tag, " R10"};
         chk(lane_d1 === e1, {tag, " lane_d1"}, lane_d1, e1);
         chk(lane_d2 === e2, {tag, " lane_d2"}, lane_d2, e2);
         chk(lane_sync === es, {tag, " lane_sync"}, lane_sync, es);

         starting = pix_valid && pix_sof && !sofd_m;
         exp_rdy  = (ph_m == 6) && en && !starting;
         chk(pix_ready === exp_rdy, "R2 R6 R9 pix_ready", pix_ready, exp_rdy);

         if (q1.size() > 0) begin
            void'(q1.pop_front()); void'(q2.pop_front());
            void'(qs.pop_front()); void'(kq.pop_front());
         end
         if (ph_m == 6) begin
            w1 = '0; w2 = '0;
            if (!en) begin
               ws = 7'b0000000; k = 0;
            end else if (starting) begin
               ws = 7'b1110000; k = 2; sofd_m = 1'b1;
            end else if (pix_valid) begin
               ws = 7'b1100100;
               w1 = pix_data[6:0];
               if (narrow_mode) begin w2 = {4'b0000, pix_data[9:7]}; k = 4; end
               else begin w2 = pix_data[13:7]; k = 3; end
               sofd_m = 1'b0;
            end else begin
               ws = 7'b1100000; k = 1;
            end
            for (int b = 6; b >= 0; b--) begin
               q1.push_back(w1[b]); q2.push_back(w2[b]);
               qs.push_back(ws[b]); kq.push_back(k);
            end
            en_b = en; mode_b = narrow_mode;
         end
         ph_m = (ph_m == 6) ? 0 : ph_m + 1;
      end
   end

   // Stimulus: every task starts and ends one time unit after a rising edge.
   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send(input logic [PW-1:0] d, input bit sof);
      pix_valid = 1'b1; pix_data = d; pix_sof = sof;
      forever begin
         @(negedge clk);
         if (pix_ready) break;
      end
      @(posedge clk); #1;
      pix_valid = 1'b0; pix_sof = 1'b0;
   endtask

   int seed = 32'h1357;
   function automatic logic [PW-1:0] next_pix();
      seed = seed * 1103515245 + 12345;
      return PW'(seed >>> 7);
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      idle(4);
      rst_n = 1'b1;          // R1: first seven clocks quiet
      en = 1'b1;
      idle(21);              // R8 idle words
      // R3 R6 R7: wide frame, extreme values
      send(14'h3FFF, 1'b1);
      send(14'h2001, 1'b0);
      send(14'h0080, 1'b0);
      idle(3);
      narrow_mode = 1'b1;    // changed mid-word, R10
      idle(9);
      // R4: narrow frame, upper bits of pix_data set to prove padding
      send(14'h3FFF, 1'b1);
      send(14'h3C00, 1'b0);
      for (int i = 0; i < 6; i++) send(next_pix(), 1'b0);
      // R10: enable dropped and restored mid-word
      idle(2); en = 1'b0; idle(2); en = 1'b1;
      idle(10);
      // R9 with R6: start-of-frame pixel held while disabled
      en = 1'b0;
      pix_valid = 1'b1; pix_sof = 1'b1; pix_data = 14'h155;
      idle(23);
      en = 1'b1;
      send(14'h155, 1'b1);
      narrow_mode = 1'b0;
      for (int i = 0; i < 8; i++) begin
         send(next_pix(), i == 0);
         if (i == 4) begin narrow_mode = 1'b1; idle(3); narrow_mode = 1'b0; end
      end
      // frame request meeting a disabling boundary
      pix_valid = 1'b1; pix_sof = 1'b1; pix_data = 14'h2AAA;
      idle(6); en = 1'b0; idle(9); en = 1'b1;
      send(14'h2AAA, 1'b1);
      idle(21);
      report();
   end
endmodule